// File: doc/BRIEF.md
# Memory Management Fault Checker

This block sits beside an address translation path and judges each access once the translation result is ready. For every access it is given the kind of access (instruction fetch or data), the modified virtual address, the access size, whether translation found a valid mapping and at which level, the domain number and its two-bit access code, and the two-bit permission field with the mode and direction of the access. It decides whether the access must be aborted. If so, it picks the single most important fault, raises an abort to the core and records the cause in status registers. Software reads these registers through a small read port.

Data faults and instruction faults are recorded differently. A data fault fills a data status register and also captures the faulting address. An instruction fetch fault only fills an instruction status register. Alignment is checked for data accesses only. The table walk and the TLB lie outside this block. It only checks the results handed to it.

The control is a two-state machine. `ST_IDLE` means no abort is pending. `ST_ABORT` means the access accepted at the previous edge faulted and the abort line is high. Transition `T_FAULT` goes from either state to `ST_ABORT` when a valid access faults. Transition `T_CLEAR` goes from either state to `ST_IDLE` when the access is invalid or clean.

Top module: `mmu_fault_unit`

## Requirements
- R1: A data access is misaligned when its size is halfword (`acc_size` 2'b01) and `acc_addr[0]` is 1, or its size is word (2'b10, and 2'b11 is treated the same) and `acc_addr[1:0]` is nonzero. The fault code is 4'b0001 and the recorded domain is 4'h0. A byte access (2'b00) is never misaligned.
- R2: An instruction fetch never produces the alignment code, whatever its address and size.
- R3: When several faults apply, only the highest one is reported. The order, from highest, is alignment, translation, domain, permission.
- R4: When `xl_ok` is 0 there is a translation fault. Its code is 4'b0101 when `xl_page` is 0 (section level) and 4'b0111 when `xl_page` is 1 (page level).
- R5: A domain code of 2'b00 (no access) or 2'b10 (reserved) gives a domain fault. Its code is 4'b1001 for a section and 4'b1011 for a page. A code of 2'b11 (manager) never gives a permission fault.
- R6: With domain code 2'b01 (client), the permission field decides. 2'b00 faults for every access. 2'b01 faults for user (`acc_priv`=0) accesses. 2'b10 faults for user writes. 2'b11 never faults. The fault code is 4'b1101 for a section and 4'b1111 for a page.
- R7: A faulting data access writes `{acc_dom, code}` into the data status register and `acc_addr` into the fault address register. The instruction status register is left unchanged.
- R8: A faulting instruction fetch writes `{acc_dom, code}` into the instruction status register. The data status and fault address registers are left unchanged.
- R9: `abort_out` is high in the cycle after a valid faulting access is sampled, and the registers change on that same edge. An access with `acc_valid` 0, or a clean access, leaves `abort_out` low and every register unchanged.
- R10: All registers reset to 0. `rd_sel` selects the value on `rd_data`: 2'b00 data status, 2'b01 instruction status, 2'b10 fault address, 2'b11 zero. The status registers are zero-extended with the code in bits [3:0] and the domain in bits [7:4].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_is_data | input | 1 | 1 data access, 0 instruction fetch |
| acc_addr | input | 32 | Modified virtual address |
| acc_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| acc_write | input | 1 | 1 write, 0 read |
| acc_priv | input | 1 | 1 privileged, 0 user |
| xl_ok | input | 1 | Translation found a valid mapping |
| xl_page | input | 1 | 1 page-level mapping, 0 section |
| acc_dom | input | 4 | Domain number of the access |
| dom_code | input | 2 | Access code of that domain |
| perm_ap | input | 2 | Permission field of the mapping |
| rd_sel | input | 2 | Register read select |
| rd_data | output | 32 | Selected register value |
| abort_out | output | 1 | Abort to the core |

## Verification
The hardest case to reach is an access that breaks several rules at once, where only the priority order decides the result. Examples are a misaligned data write to an unmapped page in a no-access domain, or a manager domain paired with a permission field that would otherwise fault. Random stimulus alone reaches such cases only now and then, so directed accesses build each overlap on purpose. Random accesses then mix fetches, data accesses and idle cycles so that each status register is seen holding its value while the other one changes.

// File: rtl/mmuf_pkg.sv
package mmuf_pkg;
    localparam int unsigned FC_W = 4;

    localparam logic [FC_W-1:0] FC_NONE    = 4'b0000;
    localparam logic [FC_W-1:0] FC_ALIGN   = 4'b0001;
    localparam logic [FC_W-1:0] FC_XL_SEC  = 4'b0101;
    localparam logic [FC_W-1:0] FC_XL_PG   = 4'b0111;
    localparam logic [FC_W-1:0] FC_DOM_SEC = 4'b1001;
    localparam logic [FC_W-1:0] FC_DOM_PG  = 4'b1011;
    localparam logic [FC_W-1:0] FC_PRM_SEC = 4'b1101;
    localparam logic [FC_W-1:0] FC_PRM_PG  = 4'b1111;

    typedef enum logic [1:0] {
        DC_NONE    = 2'b00,
        DC_CLIENT  = 2'b01,
        DC_RSVD    = 2'b10,
        DC_MANAGER = 2'b11
    } dom_code_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WIDE = 2'b11
    } acc_size_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ABORT = 1'b1
    } flt_state_e;
endpackage

// File: rtl/mmuf_align_chk.sv
module mmuf_align_chk
    import mmuf_pkg::*;
(
    input  logic       is_data,
    input  logic [1:0] addr_lo,
    input  logic [1:0] size,
    output logic       misaligned
);
    acc_size_e sz;

    always_comb begin
        sz = acc_size_e'(size);
        misaligned = 1'b0;
        if (is_data) begin
            unique case (sz)
                SZ_BYTE: misaligned = 1'b0;
                SZ_HALF: misaligned = addr_lo[0];
                SZ_WORD,
                SZ_WIDE: misaligned = |addr_lo;
            endcase
        end
    end
endmodule

// File: rtl/mmuf_access_chk.sv
module mmuf_access_chk
    import mmuf_pkg::*;
(
    input  logic [1:0] dom_code,
    input  logic [1:0] perm_ap,
    input  logic       priv,
    input  logic       write,
    output logic       dom_fault,
    output logic       perm_fault
);
    dom_code_e dc;
    logic      ap_deny;

    always_comb begin
        unique case (perm_ap)
            2'b00:   ap_deny = 1'b1;
            2'b01:   ap_deny = !priv;
            2'b10:   ap_deny = !priv && write;
            default: ap_deny = 1'b0;
        endcase
    end

    always_comb begin
        dc         = dom_code_e'(dom_code);
        dom_fault  = 1'b0;
        perm_fault = 1'b0;
        unique case (dc)
            DC_NONE,
            DC_RSVD:    dom_fault  = 1'b1;
            DC_CLIENT:  perm_fault = ap_deny;
            DC_MANAGER: perm_fault = 1'b0;
        endcase
    end
endmodule

// File: rtl/mmuf_prio.sv
module mmuf_prio
    import mmuf_pkg::*;
#(
    parameter int unsigned DOM_W = 4
) (
    input  logic             misaligned,
    input  logic             xl_ok,
    input  logic             xl_page,
    input  logic             dom_fault,
    input  logic             perm_fault,
    input  logic [DOM_W-1:0] dom_in,
    output logic             hit,
    output logic [FC_W-1:0]  code,
    output logic [DOM_W-1:0] dom_out
);
    localparam int unsigned NCLS = 4;
    logic [NCLS-1:0] cls;

    assign cls = {perm_fault, dom_fault, !xl_ok, misaligned};

    always_comb begin
        hit     = |cls;
        code    = FC_NONE;
        dom_out = dom_in;
        if (cls[0]) begin
            code    = FC_ALIGN;
            dom_out = '0;
        end else if (cls[1]) begin
            code = xl_page ? FC_XL_PG : FC_XL_SEC;
        end else if (cls[2]) begin
            code = xl_page ? FC_DOM_PG : FC_DOM_SEC;
        end else if (cls[3]) begin
            code = xl_page ? FC_PRM_PG : FC_PRM_SEC;
        end
    end
endmodule

// File: rtl/mmuf_status.sv
module mmuf_status
    import mmuf_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DOM_W  = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  acc_valid,
    input  logic                  acc_is_data,
    input  logic [ADDR_W-1:0]     acc_addr,
    input  logic                  hit,
    input  logic [FC_W-1:0]       code,
    input  logic [DOM_W-1:0]      dom,
    input  logic [1:0]            rd_sel,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  abort_out,
    output logic [FC_W+DOM_W-1:0] dfsr_o,
    output logic [FC_W+DOM_W-1:0] ifsr_o,
    output logic [ADDR_W-1:0]     far_o
);
    localparam int unsigned FSR_W = FC_W + DOM_W;

    flt_state_e st_q, st_d;
    logic [FSR_W-1:0]  dfsr_q, ifsr_q;
    logic [ADDR_W-1:0] far_q;
    logic              take;

    assign take = acc_valid && hit;

    always_comb begin
        unique case (st_q)
            ST_IDLE:  st_d = take ? ST_ABORT : ST_IDLE;
            ST_ABORT: st_d = take ? ST_ABORT : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            dfsr_q <= '0;
            ifsr_q <= '0;
            far_q  <= '0;
        end else begin
            st_q <= st_d;
            if (take) begin
                if (acc_is_data) begin
                    dfsr_q <= {dom, code};
                    far_q  <= acc_addr;
                end else begin
                    ifsr_q <= {dom, code};
                end
            end
        end
    end

    always_comb begin
        abort_out = (st_q == ST_ABORT);
        unique case (rd_sel)
            2'b00:   rd_data = DATA_W'(dfsr_q);
            2'b01:   rd_data = DATA_W'(ifsr_q);
            2'b10:   rd_data = DATA_W'(far_q);
            default: rd_data = '0;
        endcase
    end

    assign dfsr_o = dfsr_q;
    assign ifsr_o = ifsr_q;
    assign far_o  = far_q;
endmodule

// File: rtl/mmu_fault_unit.sv
module mmu_fault_unit
    import mmuf_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DOM_W  = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_is_data,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    input  logic              acc_write,
    input  logic              acc_priv,
    input  logic              xl_ok,
    input  logic              xl_page,
    input  logic [DOM_W-1:0]  acc_dom,
    input  logic [1:0]        dom_code,
    input  logic [1:0]        perm_ap,
    input  logic [1:0]        rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              abort_out
);
    localparam int unsigned FSR_W = FC_W + DOM_W;

    logic              misaligned, dom_fault, perm_fault, hit;
    logic [FC_W-1:0]   code;
    logic [DOM_W-1:0]  dom_sel;
    logic [FSR_W-1:0]  dfsr, ifsr;
    logic [ADDR_W-1:0] far;

    mmuf_align_chk u_align (
        .is_data    (acc_is_data),
        .addr_lo    (acc_addr[1:0]),
        .size       (acc_size),
        .misaligned (misaligned)
    );

    mmuf_access_chk u_access (
        .dom_code   (dom_code),
        .perm_ap    (perm_ap),
        .priv       (acc_priv),
        .write      (acc_write),
        .dom_fault  (dom_fault),
        .perm_fault (perm_fault)
    );

    mmuf_prio #(.DOM_W(DOM_W)) u_prio (
        .misaligned (misaligned),
        .xl_ok      (xl_ok),
        .xl_page    (xl_page),
        .dom_fault  (dom_fault),
        .perm_fault (perm_fault),
        .dom_in     (acc_dom),
        .hit        (hit),
        .code       (code),
        .dom_out    (dom_sel)
    );

    mmuf_status #(.ADDR_W(ADDR_W), .DOM_W(DOM_W), .DATA_W(DATA_W)) u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_valid   (acc_valid),
        .acc_is_data (acc_is_data),
        .acc_addr    (acc_addr),
        .hit         (hit),
        .code        (code),
        .dom         (dom_sel),
        .rd_sel      (rd_sel),
        .rd_data     (rd_data),
        .abort_out   (abort_out),
        .dfsr_o      (dfsr),
        .ifsr_o      (ifsr),
        .far_o       (far)
    );

    // R2: a fetch never leaves the alignment code behind
    a_r2_fetch_no_align: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !acc_is_data |=> ifsr[FC_W-1:0] != FC_ALIGN);

    // R5: manager domain skips the permission check
    a_r5_manager_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        dom_code == 2'b11 |-> !perm_fault);

    // R9: a valid faulting access raises the abort on the next cycle
    a_r9_abort_follows: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && hit |=> abort_out);

    // R9: an idle or clean access changes nothing
    a_r9_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && hit) |=> !abort_out && $stable(dfsr) && $stable(ifsr) && $stable(far));

    // R7: a data fault captures the address
    a_r7_far_capture: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_is_data && hit |=> far == $past(acc_addr));

    // R8: a fetch never moves the address register or data status
    a_r8_fetch_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !acc_is_data |=> $stable(far) && $stable(dfsr));
endmodule

// File: tb/sim_mmu_fault_unit.sv
module sim_mmu_fault_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_is_data = 1'b0, acc_write = 1'b0, acc_priv = 1'b0;
    logic        xl_ok = 1'b1, xl_page = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_size = '0, dom_code = '0, perm_ap = '0, rd_sel = '0;
    logic [3:0]  acc_dom = '0;
    logic [31:0] rd_data;
    logic        abort_out;

    int checks = 0, errors = 0;
    bit done = 0;

    logic [7:0]  m_dfsr = '0, m_ifsr = '0;
    logic [31:0] m_far = '0;

    always #10 clk = ~clk;

    mmu_fault_unit u0 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_is_data(acc_is_data),
        .acc_addr(acc_addr), .acc_size(acc_size), .acc_write(acc_write), .acc_priv(acc_priv),
        .xl_ok(xl_ok), .xl_page(xl_page), .acc_dom(acc_dom), .dom_code(dom_code),
        .perm_ap(perm_ap), .rd_sel(rd_sel), .rd_data(rd_data), .abort_out(abort_out)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference: returns {hit, dom[3:0], code[3:0]} and a requirement tag
    function automatic logic [8:0] ref_fault(input bit d, input logic [31:0] a, input logic [1:0] sz,
            input bit w, input bit p, input bit ok, input bit pg, input logic [3:0] dm,
            input logic [1:0] dc, input logic [1:0] ap, output string tag);
        bit mis, deny;
        mis  = d && ((sz == 2'b01 && a[0]) || (sz[1] && a[1:0] != 2'b00));
        deny = (ap == 2'b00) || (ap == 2'b01 && !p) || (ap == 2'b10 && !p && w);
        tag = "R9";
        if (mis)                           begin tag = "R1"; return {1'b1, 4'h0, 4'b0001}; end
        if (!ok)                           begin tag = "R4"; return {1'b1, dm, pg ? 4'b0111 : 4'b0101}; end
        if (dc == 2'b00 || dc == 2'b10)    begin tag = "R5"; return {1'b1, dm, pg ? 4'b1011 : 4'b1001}; end
        if (dc == 2'b01 && deny)           begin tag = "R6"; return {1'b1, dm, pg ? 4'b1111 : 4'b1101}; end
        return 9'h0;
    endfunction

    task automatic read_check(input string tag);
        rd_sel = 2'b00; #1; check(rd_data == {24'h0, m_dfsr}, {tag, "/R7 dfsr"}, rd_data, {24'h0, m_dfsr});
        rd_sel = 2'b01; #1; check(rd_data == {24'h0, m_ifsr}, {tag, "/R8 ifsr"}, rd_data, {24'h0, m_ifsr});
        rd_sel = 2'b10; #1; check(rd_data == m_far, {tag, "/R7 far"}, rd_data, m_far);
        rd_sel = 2'b11; #1; check(rd_data == 32'h0, "R10 unused sel", rd_data, 32'h0);
    endtask

    // Called at a negedge: apply, let one edge pass, check at the next negedge
    task automatic access(input bit v, input bit d, input logic [31:0] a, input logic [1:0] sz,
            input bit w, input bit p, input bit ok, input bit pg, input logic [3:0] dm,
            input logic [1:0] dc, input logic [1:0] ap);
        logic [8:0] r;
        string tag;
        acc_valid = v; acc_is_data = d; acc_addr = a; acc_size = sz; acc_write = w;
        acc_priv = p; xl_ok = ok; xl_page = pg; acc_dom = dm; dom_code = dc; perm_ap = ap;
        r = ref_fault(d, a, sz, w, p, ok, pg, dm, dc, ap, tag);
        if (!v) begin r[8] = 1'b0; tag = "R9 idle"; end
        if (r[8]) begin
            if (d) begin m_dfsr = r[7:0]; m_far = a; end
            else         m_ifsr = r[7:0];
        end
        @(posedge clk); @(negedge clk);
        acc_valid = 1'b0;
        check(abort_out == r[8], {tag, "/R9 abort"}, {31'h0, abort_out}, {31'h0, r[8]});
        read_check(tag);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        check(abort_out == 1'b0, "R10 reset abort", {31'h0, abort_out}, 32'h0);
        read_check("R10 reset");
        rst_n = 1'b1;
        @(negedge clk);
        // directed: R1 misaligned word, overlapping every other fault (R3)
        access(1, 1, 32'h1000_0002, 2'b10, 1, 0, 0, 1, 4'h7, 2'b00, 2'b00);
        // R2: misaligned fetch reports translation instead
        access(1, 0, 32'h2000_0003, 2'b10, 0, 0, 0, 0, 4'h3, 2'b01, 2'b11);
        // R1: byte never misaligned, halfword at odd address is
        access(1, 1, 32'h0000_0003, 2'b00, 0, 1, 1, 0, 4'h1, 2'b01, 2'b11);
        access(1, 1, 32'h0000_0005, 2'b01, 0, 1, 1, 0, 4'h1, 2'b01, 2'b11);
        // R3/R5: domain beats permission, page variant
        access(1, 1, 32'h3000_0000, 2'b10, 1, 0, 1, 1, 4'hA, 2'b10, 2'b00);
        // R5: manager with denying permission field is clean
        access(1, 1, 32'h3000_0004, 2'b10, 1, 0, 1, 1, 4'hB, 2'b11, 2'b00);
        // R6: user write to read-only, section; privileged write allowed
        access(1, 1, 32'h4000_0008, 2'b10, 1, 0, 1, 0, 4'h5, 2'b01, 2'b10);
        access(1, 1, 32'h4000_000C, 2'b10, 1, 1, 1, 0, 4'h5, 2'b01, 2'b10);
        // R8: fetch permission fault, page
        access(1, 0, 32'h5000_0000, 2'b10, 0, 0, 1, 1, 4'hC, 2'b01, 2'b01);
        // R9: invalid faulting access ignored
        access(0, 1, 32'h6000_0001, 2'b10, 1, 0, 0, 1, 4'hF, 2'b00, 2'b00);
        // random mix (R1..R10)
        for (int i = 0; i < 1500; i++) begin
            logic [31:0] rr;
            rr = $urandom;
            access(rr[0] | rr[1], rr[2], $urandom, rr[4:3], rr[5], rr[6], rr[7] | rr[8],
                   rr[9], rr[13:10], rr[15:14], rr[17:16]);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule